// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Gate Controller

This block drives the gate enable of a power switch from a fixed-rate switching cycle. At the start of every period an internal latch turns the gate on. The latch turns the gate off again when the programmed maximum on-time runs out, or earlier if an external comparator reports an overcurrent. The comparator flag is active low. It passes through a two-flop synchronizer, and it is acted on only while the gate is on and after a blanking interval that follows each turn-on. This keeps the switching spike at turn-on from causing a false trip.

A trip cuts short only the current period. The next period start turns the gate on again, so a lasting fault gives short pulses, one per period, rather than a shutdown. Period, maximum on-time and blanking time are cycle counts on configuration inputs. All three are clamped to usable values and captured at each period start. At 100 MHz, settings of 700, 400 and 58 cycles give a 7 µs period, a 4 µs maximum on-time and about 0.58 µs of blanking. A one-cycle trip flag marks each period that ended on overcurrent.

Top module: `ocg_gate_ctrl`

## Requirements
- R1: A synchronous active-high `rst` forces `gate_o`, `oc_valid_o` and `trip_o` low at the next clock edge and keeps them low while it is held. The first period starts at the first clock edge after `rst` is released, and `gate_o` is high from that edge.
- R2: `gate_o` rises once every P cycles, where P is `cfg_period_i`, or 2 if `cfg_period_i` is below 2.
- R3: With no overcurrent, `gate_o` stays high for exactly M cycles per period. M is `cfg_max_on_i` clamped to the range 1 to P-1.
- R4: The on-cycles of a period are numbered j = 0, 1, … from turn-on. `oc_valid_o` is high exactly in the on-cycles with j ≥ B, where B is `cfg_blank_i` clamped to at most M-1. An overcurrent is acted on only in those cycles.
- R5: `oc_n_i` reaches the qualifier through two flops. A low level on `oc_n_i` that is first captured at edge t can turn the gate off no earlier than edge t+2.
- R6: A synchronized low on `oc_n_i` during a cycle in which `oc_valid_o` is high turns `gate_o` off at the next edge. At that same edge `trip_o` goes high, and it stays high for exactly one cycle.
- R7: If the overcurrent is qualified at the same edge at which the maximum on-time expires, the period is counted as a trip and `trip_o` pulses.
- R8: A low on `oc_n_i` while `gate_o` is low has no effect: `trip_o` and `oc_valid_o` stay low, and the next period start still turns the gate on.
- R9: After a trip, the next period start turns `gate_o` on again. A lasting overcurrent gives one shortened pulse and one `trip_o` pulse in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period_i | input | CNT_W | Switching period in clock cycles |
| cfg_max_on_i | input | CNT_W | Maximum on-time in clock cycles |
| cfg_blank_i | input | CNT_W | Blanking time after turn-on in clock cycles |
| oc_n_i | input | 1 | Overcurrent flag from the comparator, active low |
| gate_o | output | 1 | Gate enable of the power switch |
| oc_valid_o | output | 1 | High while overcurrent is being qualified (gate on, blanking over) |
| trip_o | output | 1 | One-cycle pulse when a period ends on overcurrent |

## Verification
If the on-time counter or the captured configuration is wrong, the number of gate-high cycles in a period is wrong. That count differs from the expected value within the first period after reset. If the blanking comparison is off by one, both the number of `oc_valid_o` cycles and the trip edge move by one cycle. A synchronizer with the wrong depth shifts the trip edge of a mid-pulse fault by the missing or extra stage. If the end-cause priority is wrong, the `trip_o` pulse is lost in the period where the fault lines up with the end of the maximum on-time. If the set path is broken, the gate does not rise at the following period start.

// File: rtl/ocg_pkg.sv
`timescale 1ns/1ps
package ocg_pkg;

  // Reason a gate pulse ended at a given edge.
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_MAXON = 2'd1,
    END_TRIP  = 2'd2
  } end_cause_e;

endpackage

// File: rtl/ocg_sync.sv
`timescale 1ns/1ps
module ocg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= RST_VAL;
        else     shreg <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= {STAGES{RST_VAL}};
        else     shreg <= {shreg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = shreg[STAGES-1];

endmodule

// File: rtl/ocg_period_timer.sv
`timescale 1ns/1ps
module ocg_period_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] per_eff_i,
  output logic             start_o
);

  logic [CNT_W-1:0] pcnt;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] per_use;

  assign start_o = (pcnt == '0);
  // the new period length applies from the start edge on
  assign per_use = start_o ? per_eff_i : per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      per_q <= CNT_W'(2);
    end else begin
      if (start_o) per_q <= per_eff_i;
      if (pcnt == per_use - CNT_W'(1)) pcnt <= '0;
      else                             pcnt <= pcnt + CNT_W'(1);
    end
  end

  // R2
  period_min_chk: assert property (@(posedge clk) disable iff (rst)
    per_q >= CNT_W'(2));

endmodule

// File: rtl/ocg_gate_latch.sv
`timescale 1ns/1ps
module ocg_gate_latch
  import ocg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] mo_eff_i,
  input  logic [CNT_W-1:0] bl_eff_i,
  input  logic             oc_sync_n_i,
  output logic             gate_o,
  output logic             valid_o,
  output logic             trip_o
);

  logic             gate_q, valid_q, trip_q;
  logic [CNT_W-1:0] on_cnt, mo_q, bl_q;

  logic             gate_d;
  logic [CNT_W-1:0] on_d, mo_d, bl_d;
  logic             qual, at_max;
  end_cause_e       cause;

  assign qual   = gate_q && (on_cnt > bl_q) && !oc_sync_n_i;
  assign at_max = gate_q && (on_cnt == mo_q);

  always_comb begin
    if (qual)        cause = END_TRIP;
    else if (at_max) cause = END_MAXON;
    else             cause = END_NONE;
  end

  always_comb begin
    gate_d = gate_q;
    on_d   = on_cnt;
    mo_d   = mo_q;
    bl_d   = bl_q;
    if (cause != END_NONE) begin
      // a reset of the latch wins over a set
      gate_d = 1'b0;
      on_d   = '0;
    end else if (start_i) begin
      gate_d = 1'b1;
      on_d   = CNT_W'(1);
      mo_d   = mo_eff_i;
      bl_d   = bl_eff_i;
    end else if (gate_q) begin
      on_d   = on_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      valid_q <= 1'b0;
      trip_q  <= 1'b0;
      on_cnt  <= '0;
      mo_q    <= CNT_W'(1);
      bl_q    <= '0;
    end else begin
      gate_q  <= gate_d;
      valid_q <= gate_d && (on_d > bl_d);
      trip_q  <= (cause == END_TRIP);
      on_cnt  <= on_d;
      mo_q    <= mo_d;
      bl_q    <= bl_d;
    end
  end

  assign gate_o  = gate_q;
  assign valid_o = valid_q;
  assign trip_o  = trip_q;

  // R3
  on_time_limit_chk: assert property (@(posedge clk) disable iff (rst)
    gate_q |-> (on_cnt >= CNT_W'(1)) && (on_cnt <= mo_q));

  // R4
  valid_window_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> gate_q && (on_cnt > bl_q));

  // R6
  trip_single_chk: assert property (@(posedge clk) disable iff (rst)
    trip_q |=> !trip_q);

  // R6
  trip_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    trip_q |-> !gate_q && $fell(gate_q));

endmodule

// File: rtl/ocg_gate_ctrl.sv
`timescale 1ns/1ps
module ocg_gate_ctrl #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [CNT_W-1:0] cfg_max_on_i,
  input  logic [CNT_W-1:0] cfg_blank_i,
  input  logic             oc_n_i,
  output logic             gate_o,
  output logic             oc_valid_o,
  output logic             trip_o
);

  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);

  logic [CNT_W-1:0] per_eff, mo_eff, bl_eff;
  logic             start, oc_sync_n;

  // clamp the configuration to values that keep one off-cycle per period
  always_comb begin
    per_eff = (cfg_period_i < MIN_PERIOD) ? MIN_PERIOD : cfg_period_i;
    if (cfg_max_on_i == '0)          mo_eff = CNT_W'(1);
    else if (cfg_max_on_i >= per_eff) mo_eff = per_eff - CNT_W'(1);
    else                              mo_eff = cfg_max_on_i;
    bl_eff = (cfg_blank_i >= mo_eff) ? mo_eff - CNT_W'(1) : cfg_blank_i;
  end

  ocg_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) oc_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (oc_n_i),
    .q_o (oc_sync_n)
  );

  ocg_period_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .per_eff_i (per_eff),
    .start_o   (start)
  );

  ocg_gate_latch #(
    .CNT_W (CNT_W)
  ) latch_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .mo_eff_i    (mo_eff),
    .bl_eff_i    (bl_eff),
    .oc_sync_n_i (oc_sync_n),
    .gate_o      (gate_o),
    .valid_o     (oc_valid_o),
    .trip_o      (trip_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !gate_o && !oc_valid_o && !trip_o);

  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> $past(start));

  // R8
  valid_needs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_o |-> !oc_valid_o);

endmodule

// File: tb/ocg_gate_ctrl_tb.sv
`timescale 1ns/1ps
module ocg_gate_ctrl_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cfg_period = W'(20);
  logic [W-1:0] cfg_max_on = W'(8);
  logic [W-1:0] cfg_blank  = W'(3);
  logic         oc_n = 1'b1;
  logic         gate_o, oc_valid_o, trip_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ocg_gate_ctrl #(.CNT_W(W), .SYNC_STAGES(2)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_period_i (cfg_period),
    .cfg_max_on_i (cfg_max_on),
    .cfg_blank_i  (cfg_blank),
    .oc_n_i       (oc_n),
    .gate_o       (gate_o),
    .oc_valid_o   (oc_valid_o),
    .trip_o       (trip_o)
  );

  // per, max_on, blank, d, exp gate cycles, exp trips, exp valid cycles, exp period
  // d >= 0: oc_n driven low d negedges after the first gate-high sample
  // d = -1: no overcurrent, d = -2: oc_n low from reset on
  localparam int NV = 12;
  localparam int VEC [NV][8] = '{
    '{20,  8,  3, -1, 8, 0, 5, 20},  // R3 R4 plain period
    '{20,  8,  3, -2, 4, 1, 1, 20},  // R4 R6 held fault trips right after blanking
    '{20,  8,  3,  0, 4, 1, 1, 20},  // R4 R5 fault inside blanking
    '{20,  8,  3,  2, 5, 1, 2, 20},  // R5 R6 two-stage latency
    '{20,  8,  3,  5, 8, 1, 5, 20},  // R7 fault lands on max on-time edge
    '{20,  8,  3,  6, 8, 0, 5, 20},  // R3 fault too late for this pulse
    '{20,  8,  0,  0, 3, 1, 3, 20},  // R5 no blanking, latency only
    '{20,  6, 10, -2, 6, 1, 1, 20},  // R4 blanking clamped to M-1
    '{10, 15,  2, -1, 9, 0, 7, 10},  // R3 max on clamped to P-1
    '{ 1,  1,  0, -1, 1, 0, 1,  2},  // R2 period clamped to 2
    '{30, 12,  4, -2, 5, 1, 1, 30},  // R6 other timing
    '{16, 10,  1,  4, 7, 1, 6, 16}   // R5 R6 mid-pulse fault
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_period(input int d, output int g, output int t,
                            output int v, output int p);
    bit found;
    logic prev;
    g = 0; t = 0; v = 0; p = -1;
    found = 1'b0;
    for (int i = 0; i < 10 && !found; i++) begin
      @(negedge clk);
      if (gate_o) found = 1'b1;
    end
    if (!found) return;
    prev = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      if (k > 0) @(negedge clk);
      if (k > 0 && gate_o && !prev) begin
        p = k;
        break;
      end
      g += int'(gate_o);
      t += int'(trip_o);
      v += int'(oc_valid_o);
      if (d >= 0 && k == d) oc_n = 1'b0;
      prev = gate_o;
    end
  endtask

  initial begin : watchdog
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int g, t, v, p, acc_g, acc_t, acc_v;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 gate in reset", int'(gate_o), 0);
    check("R1 valid in reset", int'(oc_valid_o), 0);
    check("R1 trip in reset", int'(trip_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 gate on first edge after reset", int'(gate_o), 1);

    // table walk
    for (int n = 0; n < NV; n++) begin
      cfg_period = W'(VEC[n][0]);
      cfg_max_on = W'(VEC[n][1]);
      cfg_blank  = W'(VEC[n][2]);
      oc_n = (VEC[n][3] == -2) ? 1'b0 : 1'b1;
      do_reset();
      run_period(VEC[n][3], g, t, v, p);
      oc_n = 1'b1;
      check($sformatf("R3/R6 gate cycles vec%0d", n), g, VEC[n][4]);
      check($sformatf("R6/R7 trips vec%0d", n), t, VEC[n][5]);
      check($sformatf("R4 valid cycles vec%0d", n), v, VEC[n][6]);
      check($sformatf("R2 period vec%0d", n), p, VEC[n][7]);
    end

    // R9 held fault: every period restarts, trips and is shortened
    cfg_period = W'(20); cfg_max_on = W'(8); cfg_blank = W'(3);
    oc_n = 1'b0;
    do_reset();
    acc_g = 0; acc_t = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      acc_g += int'(gate_o);
      acc_t += int'(trip_o);
    end
    check("R9 gate cycles over 3 periods", acc_g, 12);
    check("R9 trips over 3 periods", acc_t, 3);
    oc_n = 1'b1;

    // R8 fault while gate is off is ignored
    do_reset();
    acc_g = 0; acc_t = 0; acc_v = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k >= 9) begin
        acc_g += int'(gate_o);
        acc_t += int'(trip_o);
        acc_v += int'(oc_valid_o);
      end
      if (k == 9) oc_n = 1'b0;
    end
    check("R8 gate while off", acc_g, 0);
    check("R8 trip while off", acc_t, 0);
    check("R8 valid while off", acc_v, 0);
    @(negedge clk);
    check("R8 next period still starts", int'(gate_o), 1);
    oc_n = 1'b1;

    // R1 reset in the middle of an on-time
    do_reset();
    repeat (3) @(negedge clk);
    check("R1 gate high before mid reset", int'(gate_o), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 gate after mid reset", int'(gate_o), 0);
    check("R1 valid after mid reset", int'(oc_valid_o), 0);
    check("R1 trip after mid reset", int'(trip_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule